// File: doc/BRIEF.md
# Three-Coil Low-Frequency Wake-Up Sequencer

This block controls a wake-up receiver that has three coil front-ends, one per spatial axis. While nothing is being received it moves through a fixed loop. First a standby gap, with every coil switched off. Then a listen slot on one coil. Then another gap, and the next listen slot on the next coil. The coils are visited in a fixed rotation. The timing comes from a slow tick derived from an RC oscillator, so the front-ends draw current only for short, regular windows.

When the active coil reports a carrier during its listen slot, the sequencer stays on that coil. It decodes Manchester half-bit symbols sampled from that coil and first compares them against a configured 8-bit header. If the header matches, it assembles the following payload bits into bytes and writes them into an 8-byte receive FIFO, which the host drains one byte at a time. A completed payload raises a sticky done flag. A code violation or a FIFO overrun during the payload drops the frame, raises a sticky error flag and returns the block to standby. The block does not try to resynchronise.

Top module: `lfw_wake_seq`

## Requirements
- R1: After reset, status_o is 0 and coil_en_o is 0. Both IRQ flags are 0, fifo_count_o is 0, and coil 0 is the first coil to listen. The status encoding is 0 = standby, 1 = listen, 2 = header check, 3 = payload.
- R2: In standby all coil enables are 0. Standby lasts exactly 2*(cfg_stby_i+1) tick_i pulses, and the block enters listen on the clock edge that takes the last of them.
- R3: Coils are listened to in the order 0, 1, 2, 0, ..., where coil k is enable bit k. Each exit from listen, header check or payload to standby moves the selection to the next coil.
- R4: In listen exactly one coil enable is set, the selected one. A carrier on the selected coil moves the block to header check on the next edge. A carrier on any other coil is ignored. With no carrier, the block returns to standby on the (cfg_listen_i+1)-th tick.
- R5: Symbols are taken in pairs on sym_valid_i strobes. With cfg_pol_i=0, the pair 01 (first symbol 0) decodes to 0 and 10 decodes to 1. With cfg_pol_i=1 the mapping is reversed. The pairs 00 and 11 are code violations.
- R6: The first 8 decoded bits are compared with cfg_hdr_i, starting at bit 7. A full match enters payload. A mismatching bit or a violation during the header returns the block to standby at once, with no IRQ.
- R7: With cfg_msb_first_i=0 the first payload bit of each byte lands in bit 0. With cfg_msb_first_i=1 it lands in bit 7.
- R8: The FIFO holds 8 bytes. fifo_wr_o pulses once per accepted byte, with the byte on fifo_wdata_o. fifo_rdata_o shows the oldest byte, fifo_rd_i removes it, and a read of an empty FIFO has no effect.
- R9: A payload is cfg_nbytes_i+1 bytes long. After the last byte is written, irq_done_o is set and the block returns to standby.
- R10: A code violation during the payload returns the block to standby and sets irq_err_o.
- R11: A byte that completes while the FIFO holds 8 bytes is dropped. The block returns to standby, sets irq_err_o, and leaves the FIFO contents unchanged.
- R12: irq_done_o and irq_err_o stay set until irq_clr_i clears them. A new set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per RC clock period |
| carrier_i | input | 3 | Carrier detect, one bit per coil |
| sym_valid_i | input | 1 | Strobe for one sampled half-bit symbol |
| sym_i | input | 1 | Sampled symbol from the active coil |
| cfg_pol_i | input | 1 | Manchester polarity select |
| cfg_msb_first_i | input | 1 | Byte assembly order select |
| cfg_stby_i | input | 4 | Standby length code |
| cfg_listen_i | input | 8 | Listen window length minus one, in ticks |
| cfg_hdr_i | input | 8 | Expected header pattern |
| cfg_nbytes_i | input | 4 | Payload length minus one, in bytes |
| fifo_rd_i | input | 1 | Pop the oldest FIFO byte |
| irq_clr_i | input | 1 | Clear both IRQ flags |
| coil_en_o | output | 3 | Coil front-end enables |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |
| fifo_rdata_o | output | 8 | Oldest FIFO byte |
| fifo_count_o | output | 4 | Bytes held in the FIFO |
| status_o | output | 2 | Sequencer state |
| irq_done_o | output | 1 | Sticky payload-complete flag |
| irq_err_o | output | 1 | Sticky payload-abort flag |

## Verification
The hardest state to reach from the ports is an overrun. It needs a full header match and then nine complete payload bytes on one coil, with the host never draining the FIFO. The bench gets there by setting a payload length of ten bytes and streaming nine. It then checks that the FIFO still holds exactly the first eight, in order, and that the error flag is set and the done flag is not. A Manchester violation part-way through a payload is reached in a similar way: a clean header, followed by two equal half-bit symbols.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

    localparam int NCOIL      = 3;
    localparam int SEL_W      = 2;
    localparam int BYTE_W     = 8;
    localparam int FIFO_DEPTH = 8;
    localparam int TICK_W     = 8;

    typedef enum logic [1:0] {
        ST_STBY   = 2'd0,
        ST_LISTEN = 2'd1,
        ST_HDR    = 2'd2,
        ST_PAY    = 2'd3
    } lfw_state_e;

    typedef struct packed {
        logic valid;
        logic data;
        logic viol;
    } lfw_bit_t;

    // standby length in ticks: two per step of the code, minimum two
    function automatic logic [5:0] stby_ticks(input logic [3:0] code);
        return ({2'b00, code} + 6'd1) << 1;
    endfunction

    // pair (first, second) to data bit under the polarity select
    function automatic logic manch_value(input logic first, input logic second,
                                         input logic pol);
        return pol ? second : first;
    endfunction

    function automatic logic [SEL_W-1:0] next_coil(input logic [SEL_W-1:0] sel);
        return (sel == SEL_W'(NCOIL - 1)) ? '0 : sel + 1'b1;
    endfunction

endpackage

// File: rtl/lfw_tick_timer.sv
module lfw_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);

    logic [W-1:0] cnt_q;

    assign expire_o = tick_i && !clr_i && (cnt_q == limit_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i || expire_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2/R4: the count cannot run on after clearing is requested
    a_r2_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/lfw_manch_dec.sv
module lfw_manch_dec
    import lfw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     sym_valid_i,
    input  logic     sym_i,
    input  logic     pol_i,
    output lfw_bit_t bit_o
);

    logic half_q;
    logic first_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            half_q  <= 1'b0;
            first_q <= 1'b0;
            bit_o   <= '0;
        end else begin
            bit_o.valid <= 1'b0;
            if (sym_valid_i) begin
                if (!half_q) begin
                    first_q <= sym_i;
                    half_q  <= 1'b1;
                end else begin
                    half_q      <= 1'b0;
                    bit_o.valid <= 1'b1;
                    bit_o.data  <= manch_value(first_q, sym_i, pol_i);
                    bit_o.viol  <= (first_q == sym_i);
                end
            end
        end
    end

    // R5: every decoded bit is the product of a symbol strobe
    a_r5_pair_origin: assert property (@(posedge clk) disable iff (rst)
        bit_o.valid |-> $past(sym_valid_i));

endmodule

// File: rtl/lfw_rx_fifo.sv
module lfw_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             rd_i,
    output logic [W-1:0]     rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_wr, do_rd;

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign do_wr   = wr_i && !full_o;
    assign do_rd   = rd_i && (cnt_q != '0);
    assign rdata_o = mem_q[rptr_q];
    assign count_o = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) begin
                wptr_q <= bump(wptr_q);
            end
            if (do_rd) begin
                rptr_q <= bump(rptr_q);
            end
            cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wptr_q] <= wdata_i;
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !wr_i && cnt_q == '0) |=> (cnt_q == '0));

    a_r11_full_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !rd_i && full_o) |=> $stable(cnt_q));

endmodule

// File: rtl/lfw_wake_seq.sv
module lfw_wake_seq
    import lfw_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int TW    = TICK_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [2:0]       carrier_i,
    input  logic             sym_valid_i,
    input  logic             sym_i,
    input  logic             cfg_pol_i,
    input  logic             cfg_msb_first_i,
    input  logic [3:0]       cfg_stby_i,
    input  logic [TW-1:0]    cfg_listen_i,
    input  logic [7:0]       cfg_hdr_i,
    input  logic [3:0]       cfg_nbytes_i,
    input  logic             fifo_rd_i,
    input  logic             irq_clr_i,
    output logic [2:0]       coil_en_o,
    output logic             fifo_wr_o,
    output logic [7:0]       fifo_wdata_o,
    output logic [7:0]       fifo_rdata_o,
    output logic [CNT_W-1:0] fifo_count_o,
    output logic [1:0]       status_o,
    output logic             irq_done_o,
    output logic             irq_err_o
);

    lfw_state_e       st_q, st_n;
    logic [SEL_W-1:0] sel_q, sel_n;
    logic [2:0]       bitcnt_q, bitcnt_n;
    logic [3:0]       bytecnt_q, bytecnt_n;
    logic [7:0]       byte_q, byte_n, byte_shift;
    logic             set_done, set_err, wr;
    logic             tmr_clr, tmr_exp;
    logic [TW-1:0]    tmr_limit;
    logic             coil_active, car_act, fifo_full;
    logic [NCOIL-1:0] sel_onehot;
    lfw_bit_t         dbit;

    // ---------------- coil selection ----------------
    assign coil_active = (st_q != ST_STBY);

    for (genvar g = 0; g < NCOIL; g++) begin : g_coil
        assign sel_onehot[g] = (sel_q == SEL_W'(g));
        assign coil_en_o[g]  = coil_active && sel_onehot[g];
    end

    assign car_act = |(carrier_i & sel_onehot);

    // ---------------- slot timer ----------------
    assign tmr_clr   = !(st_q == ST_STBY || st_q == ST_LISTEN);
    assign tmr_limit = (st_q == ST_STBY) ? TW'(stby_ticks(cfg_stby_i) - 6'd1)
                                         : cfg_listen_i;

    lfw_tick_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (tmr_clr),
        .tick_i   (tick_i),
        .limit_i  (tmr_limit),
        .expire_o (tmr_exp)
    );

    // ---------------- symbol decoder ----------------
    lfw_manch_dec u_dec (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (!(st_q == ST_HDR || st_q == ST_PAY)),
        .sym_valid_i (sym_valid_i),
        .sym_i       (sym_i),
        .pol_i       (cfg_pol_i),
        .bit_o       (dbit)
    );

    // ---------------- receive FIFO ----------------
    lfw_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .wdata_i (byte_shift),
        .rd_i    (fifo_rd_i),
        .rdata_o (fifo_rdata_o),
        .count_o (fifo_count_o),
        .full_o  (fifo_full)
    );

    assign fifo_wr_o    = wr;
    assign fifo_wdata_o = byte_shift;

    // ---------------- sequencer ----------------
    assign byte_shift = cfg_msb_first_i ? {byte_q[6:0], dbit.data}
                                        : {dbit.data, byte_q[7:1]};

    always_comb begin
        st_n      = st_q;
        sel_n     = sel_q;
        bitcnt_n  = bitcnt_q;
        bytecnt_n = bytecnt_q;
        byte_n    = byte_q;
        set_done  = 1'b0;
        set_err   = 1'b0;
        wr        = 1'b0;
        unique case (st_q)
            ST_STBY: begin
                if (tmr_exp) begin
                    st_n = ST_LISTEN;
                end
            end
            ST_LISTEN: begin
                if (car_act) begin
                    st_n     = ST_HDR;
                    bitcnt_n = '0;
                end else if (tmr_exp) begin
                    st_n  = ST_STBY;
                    sel_n = next_coil(sel_q);
                end
            end
            ST_HDR: begin
                if (dbit.valid) begin
                    if (dbit.viol || (dbit.data != cfg_hdr_i[3'd7 - bitcnt_q])) begin
                        st_n  = ST_STBY;
                        sel_n = next_coil(sel_q);
                    end else if (bitcnt_q == 3'd7) begin
                        st_n      = ST_PAY;
                        bitcnt_n  = '0;
                        bytecnt_n = '0;
                    end else begin
                        bitcnt_n = bitcnt_q + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (dbit.valid) begin
                    if (dbit.viol) begin
                        st_n    = ST_STBY;
                        sel_n   = next_coil(sel_q);
                        set_err = 1'b1;
                    end else begin
                        byte_n   = byte_shift;
                        bitcnt_n = bitcnt_q + 1'b1;
                        if (bitcnt_q == 3'd7) begin
                            if (fifo_full) begin
                                st_n    = ST_STBY;
                                sel_n   = next_coil(sel_q);
                                set_err = 1'b1;
                            end else begin
                                wr = 1'b1;
                                if (bytecnt_q == cfg_nbytes_i) begin
                                    st_n     = ST_STBY;
                                    sel_n    = next_coil(sel_q);
                                    set_done = 1'b1;
                                end else begin
                                    bytecnt_n = bytecnt_q + 1'b1;
                                end
                            end
                        end
                    end
                end
            end
            default: st_n = ST_STBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_STBY;
            sel_q      <= '0;
            bitcnt_q   <= '0;
            bytecnt_q  <= '0;
            byte_q     <= '0;
            irq_done_o <= 1'b0;
            irq_err_o  <= 1'b0;
        end else begin
            st_q       <= st_n;
            sel_q      <= sel_n;
            bitcnt_q   <= bitcnt_n;
            bytecnt_q  <= bytecnt_n;
            byte_q     <= byte_n;
            irq_done_o <= set_done || (irq_done_o && !irq_clr_i);
            irq_err_o  <= set_err  || (irq_err_o  && !irq_clr_i);
        end
    end

    assign status_o = st_q;

    // ---------------- assertions ----------------
    a_r2_coils_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(coil_en_o));

    a_r4_listen_one_coil: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LISTEN) |-> ($countones(coil_en_o) == 1));

    a_r3_coil_advance: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_STBY && st_n == ST_STBY) |=> (sel_q == next_coil($past(sel_q))));

    a_r10_viol_abort: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAY && dbit.valid && dbit.viol) |=> (st_q == ST_STBY && irq_err_o));

    a_r11_overrun_abort: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAY && dbit.valid && !dbit.viol && bitcnt_q == 3'd7 && fifo_full)
        |=> (st_q == ST_STBY && irq_err_o));

    a_r12_done_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_done_o && !irq_clr_i) |=> irq_done_o);

    a_r12_err_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_err_o && !irq_clr_i) |=> irq_err_o);

endmodule

// File: tb/sim_lfw_wake_seq.sv
module sim_lfw_wake_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] carrier = '0;
    logic       sym_valid = 1'b0, sym = 1'b0;
    logic       pol = 1'b0, msb = 1'b0;
    logic [3:0] stby = 4'd1;
    logic [7:0] listen = 8'd2;
    logic [7:0] hdr = 8'hA5;
    logic [3:0] nbytes = 4'd0;
    logic       rd = 1'b0, iclr = 1'b0;

    logic [2:0] coil_en;
    logic       fwr;
    logic [7:0] fwdata, frdata;
    logic [3:0] fcount;
    logic [1:0] status;
    logic       irq_done, irq_err;

    int n_chk = 0, n_bad = 0, wr_seen = 0, exp_sel = 0;
    bit done_flag = 0;
    logic [7:0] pay [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lfw_wake_seq u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .carrier_i(carrier),
        .sym_valid_i(sym_valid), .sym_i(sym), .cfg_pol_i(pol),
        .cfg_msb_first_i(msb), .cfg_stby_i(stby), .cfg_listen_i(listen),
        .cfg_hdr_i(hdr), .cfg_nbytes_i(nbytes), .fifo_rd_i(rd),
        .irq_clr_i(iclr), .coil_en_o(coil_en), .fifo_wr_o(fwr),
        .fifo_wdata_o(fwdata), .fifo_rdata_o(frdata), .fifo_count_o(fcount),
        .status_o(status), .irq_done_o(irq_done), .irq_err_o(irq_err)
    );

    always @(negedge clk) if (!rst && fwr) wr_seen++;

    function automatic int stby_len(input logic [3:0] c);
        return 2 * (int'(c) + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic send_sym(input logic s);
        @(negedge clk) begin sym_valid = 1'b1; sym = s; end
        @(negedge clk) sym_valid = 1'b0;
    endtask

    task automatic send_bit(input logic d);
        send_sym(d ^ pol);
        send_sym(~(d ^ pol));
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(msb ? b[7 - i] : b[i]);
    endtask

    task automatic to_listen();
        ticks(stby_len(stby));
        chk("R2 enter listen", int'(status), 1);
        chk("R3 coil order", int'(coil_en), 1 << exp_sel);
    endtask

    task automatic catch_carrier();
        @(negedge clk) carrier = 3'(1 << exp_sel);
        @(negedge clk) carrier = '0;
        chk("R4 carrier to header", int'(status), 2);
    endtask

    task automatic send_header();
        for (int i = 7; i >= 0; i--) send_bit(hdr[i]);
        @(negedge clk);
        chk("R6 header match", int'(status), 3);
    endtask

    task automatic clear_irq();
        @(negedge clk) iclr = 1'b1;
        @(negedge clk) iclr = 1'b0;
        chk("R12 clear done", int'(irq_done), 0);
        chk("R12 clear err", int'(irq_err), 0);
    endtask

    task automatic drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(frdata), int'(pay[i]));
            @(negedge clk) rd = 1'b1;
            @(negedge clk) rd = 1'b0;
        end
        chk("R8 drained", int'(fcount), 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int w0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", int'(status), 0);
        chk("R1 coils", int'(coil_en), 0);
        chk("R1 irq_done", int'(irq_done), 0);
        chk("R1 irq_err", int'(irq_err), 0);
        chk("R1 fifo", int'(fcount), 0);

        // R2 standby length, R3/R4 rotation with empty listen slots
        ticks(stby_len(stby) - 1);
        chk("R2 still standby", int'(status), 0);
        chk("R2 coils off", int'(coil_en), 0);
        do_tick();
        chk("R2 listen", int'(status), 1);
        chk("R3 first coil", int'(coil_en), 1);
        @(negedge clk) carrier = 3'b110;
        repeat (3) @(negedge clk);
        carrier = '0;
        chk("R4 other coil ignored", int'(status), 1);
        ticks(int'(listen));
        chk("R4 window open", int'(status), 1);
        do_tick();
        chk("R4 window expire", int'(status), 0);
        exp_sel = 1;
        for (int k = 0; k < 3; k++) begin
            to_listen();
            ticks(int'(listen) + 1);
            chk("R3 back to standby", int'(status), 0);
            exp_sel = (exp_sel + 1) % 3;
        end

        // random frames
        for (int f = 0; f < 6; f++) begin
            pol    = 1'($urandom);
            msb    = 1'($urandom);
            hdr    = 8'($urandom);
            stby   = 4'($urandom_range(0, 5));
            nbytes = 4'($urandom_range(0, 7));
            for (int i = 0; i <= int'(nbytes); i++) pay[i] = 8'($urandom);
            to_listen();
            catch_carrier();
            send_header();
            w0 = wr_seen;
            for (int i = 0; i <= int'(nbytes); i++) send_byte(pay[i]);
            @(negedge clk);
            chk("R9 back to standby", int'(status), 0);
            chk("R9 irq_done", int'(irq_done), 1);
            chk("R8 write pulses", wr_seen - w0, int'(nbytes) + 1);
            chk("R8 count", int'(fcount), int'(nbytes) + 1);
            exp_sel = (exp_sel + 1) % 3;
            repeat (4) @(negedge clk);
            chk("R12 done held", int'(irq_done), 1);
            drain(int'(nbytes) + 1, pol ? "R5 R7 byte pol1" : "R5 R7 byte pol0");
            clear_irq();
        end

        // R7 directed: same byte both orders
        pol = 1'b0; stby = 4'd0; nbytes = 4'd0; pay[0] = 8'h1E;
        for (int o = 0; o < 2; o++) begin
            msb = 1'(o);
            to_listen();
            catch_carrier();
            send_header();
            send_byte(8'h1E);
            @(negedge clk);
            drain(1, "R7 order");
            exp_sel = (exp_sel + 1) % 3;
            clear_irq();
        end

        // R6 header mismatch on first bit
        to_listen();
        catch_carrier();
        send_bit(~hdr[7]);
        @(negedge clk);
        chk("R6 mismatch to standby", int'(status), 0);
        chk("R6 no done irq", int'(irq_done), 0);
        chk("R6 no err irq", int'(irq_err), 0);
        exp_sel = (exp_sel + 1) % 3;

        // R10 violation in payload
        to_listen();
        catch_carrier();
        send_header();
        send_sym(1'b1);
        send_sym(1'b1);
        @(negedge clk);
        chk("R10 abort", int'(status), 0);
        chk("R10 irq_err", int'(irq_err), 1);
        chk("R10 no done", int'(irq_done), 0);
        exp_sel = (exp_sel + 1) % 3;
        clear_irq();

        // R11 overrun: ten-byte payload, nine sent, no reads
        nbytes = 4'd9;
        for (int i = 0; i < 9; i++) pay[i] = 8'(8'h30 + i * 7);
        to_listen();
        catch_carrier();
        send_header();
        for (int i = 0; i < 9; i++) send_byte(pay[i]);
        @(negedge clk);
        chk("R11 abort", int'(status), 0);
        chk("R11 irq_err", int'(irq_err), 1);
        chk("R11 no done", int'(irq_done), 0);
        chk("R11 fifo full", int'(fcount), 8);
        drain(8, "R11 contents");
        exp_sel = (exp_sel + 1) % 3;

        // R8 read on empty FIFO
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        chk("R8 empty read", int'(fcount), 0);
        clear_irq();
        to_listen();

        finish_run();
    end

endmodule